// File: doc/BRIEF.md
# Edge Interrupt Line Bank

This block watches a bank of asynchronous external input lines and turns selected transitions on them into interrupt requests. Each line passes through a two-stage synchronizer. A third stage holds the previous value so that the block can detect low-to-high and high-to-low changes. Software picks the sensitivity for each line through two independent registers, one for rising edges and one for falling edges. A line with both bits set responds to either edge.

A qualifying edge on an enabled line sets a sticky pending bit. The pending bit stays set until software writes a 1 to its position. The block drives one level request toward a downstream interrupt controller. The request is high while any pending bit is set on an enabled line. A separate write-only register lets software set pending bits directly for test purposes.

Configuration uses a simple single-cycle write port and a combinational read port that share one address.

Top module: `edge_irq_bank`

## Requirements
- R1: After reset, every register reads 0 and `irq_req` is low. The register addresses are 0 for enable, 1 for rising select, 2 for falling select, 3 for software set and 4 for pending. Bit i of each register belongs to line i.
- R2: The enable, rising-select and falling-select registers read back the value last written to them.
- R3: A low-to-high change on a line whose rising-select and enable bits are both 1 sets that line's pending bit. The pending bit then holds until it is cleared.
- R4: A line with only its falling-select bit set ignores a rising change and sets pending on a falling change.
- R5: A line with both select bits set sets pending on either edge.
- R6: An edge on a line whose enable bit is 0 does not set pending, regardless of its select bits.
- R7: Writing to the pending address clears exactly the bits written as 1 and leaves the other bits unchanged.
- R8: When a qualifying edge and a clear of the same bit land in the same cycle, the pending bit stays set.
- R9: Writing to the software-set address sets the pending bits written as 1, whatever the enable bits are. This address always reads 0.
- R10: `irq_req` is high exactly when some bit is set in both pending and enable. Turning on the enable of an already pending line raises the request.
- R11: Pending becomes visible on the third rising clock edge after the input changes, and not on the second (two synchronizer flops plus one pending register).
- R12: The highest-numbered line, 22, behaves the same as line 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 23 | Asynchronous external lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 23 | Write data |
| reg_rdata | output | 23 | Read data for `reg_addr` |
| irq_req | output | 1 | Request to the downstream interrupt controller |

## Verification
The bench clears a pending bit in the same cycle that a new edge on that line reaches the pending stage. A design that lets the clear win would lose that interrupt. The bench samples pending one cycle before and one cycle after it is due. This exposes a synchronizer that is too short, which would flag edges a cycle early, or a pipeline with an extra stage, which would flag them late. It also sends edges that are selected but masked, and edges on the edge that is not selected. These expose a mask applied only at the request instead of at the pending bit, and select bits that are swapped. Finally, it sets a pending bit through software on a disabled line and then enables that line. A request that ignored the mask, or that was computed from edges instead of pending bits, would show up here.

// File: rtl/edge_irq_bank.sv
module edge_irq_bank #(
  parameter int NL = 23,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] line_in,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [NL-1:0] reg_wdata,
  output logic [NL-1:0] reg_rdata,
  output logic          irq_req
);
  localparam logic [AW-1:0] A_ENA  = AW'(0);
  localparam logic [AW-1:0] A_RISE = AW'(1);
  localparam logic [AW-1:0] A_FALL = AW'(2);
  localparam logic [AW-1:0] A_SW   = AW'(3);
  localparam logic [AW-1:0] A_PEND = AW'(4);

  logic [NL-1:0] s1, s2, s3;
  logic [NL-1:0] ena, rsel, fsel, pend;
  logic [NL-1:0] hit, sw_set, clr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= line_in; s2 <= s1; s3 <= s2;
    end

  assign hit    = ((s2 & ~s3 & rsel) | (~s2 & s3 & fsel)) & ena;
  assign sw_set = (reg_we && reg_addr == A_SW)   ? reg_wdata : '0;
  assign clr    = (reg_we && reg_addr == A_PEND) ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ena <= '0; rsel <= '0; fsel <= '0; pend <= '0;
    end else begin
      if (reg_we && reg_addr == A_ENA)  ena  <= reg_wdata;
      if (reg_we && reg_addr == A_RISE) rsel <= reg_wdata;
      if (reg_we && reg_addr == A_FALL) fsel <= reg_wdata;
      pend <= (pend & ~clr) | hit | sw_set;
    end

  always_comb
    case (reg_addr)
      A_ENA:   reg_rdata = ena;
      A_RISE:  reg_rdata = rsel;
      A_FALL:  reg_rdata = fsel;
      A_PEND:  reg_rdata = pend;
      default: reg_rdata = '0;
    endcase

  assign irq_req = |(pend & ena);
endmodule

module edge_irq_bank_chk #(
  parameter int NL = 23,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [NL-1:0] reg_wdata,
  input logic [NL-1:0] ena,
  input logic [NL-1:0] pend,
  input logic [NL-1:0] s2,
  input logic [NL-1:0] s3,
  input logic          irq_req
);
  localparam logic [AW-1:0] A_ENA  = AW'(0);
  localparam logic [AW-1:0] A_SW   = AW'(3);
  localparam logic [AW-1:0] A_PEND = AW'(4);

  // R3
  sticky_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_PEND) |=> ((($past(pend)) & ~pend) == '0));

  // R6
  masked_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_SW) |=> ((pend & ~$past(pend) & ~$past(ena)) == '0));

  // R11
  sync_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_SW) |=> ((pend & ~$past(pend) & ~($past(s2) ^ $past(s3))) == '0));

  // R10
  req_needs_ena_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (ena != '0));

  // R10
  req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> !irq_req);

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_PEND && !(s2 ^ s3) != 1'b0 && (s2 == s3))
      |=> ((pend & $past(reg_wdata)) == '0));

  // R2
  ena_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_ENA) |=> $stable(ena));
endmodule

bind edge_irq_bank edge_irq_bank_chk #(.NL(NL), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ena(ena), .pend(pend), .s2(s2), .s3(s3),
  .irq_req(irq_req)
);

// File: tb/edge_irq_bank_bench.sv
`timescale 1ns/100ps
module edge_irq_bank_bench;
  localparam int NL = 23;
  localparam int AW = 3;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [NL-1:0] line_in = '0;
  logic          reg_we = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [NL-1:0] reg_wdata = '0;
  logic [NL-1:0] reg_rdata;
  logic          irq_req;

  edge_irq_bank #(.NL(NL), .AW(AW)) u_edge_irq_bank (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    string         req;
    logic [NL-1:0] exp;
    logic          exp_irq;
  } item_t;

  item_t q[$];
  event  sample_ev;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  initial forever begin
    @(sample_ev);
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (reg_rdata !== it.exp || irq_req !== it.exp_irq) begin
        errors++;
        $display("FAIL %s addr %0d rdata %h exp %h irq %b exp %b",
                 it.req, reg_addr, reg_rdata, it.exp, irq_req, it.exp_irq);
      end
    end
  end

  task automatic expect_rd(string req, logic [AW-1:0] a, logic [NL-1:0] e, logic ei);
    item_t it;
    reg_addr = a;
    #0.5;
    it.req = req; it.exp = e; it.exp_irq = ei;
    q.push_back(it);
    -> sample_ev;
    #0.5;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [NL-1:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic set_line(int idx, logic v);
    @(negedge clk);
    line_in[idx] = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    expect_rd("R1 ena", 0, '0, 0);
    expect_rd("R1 rise", 1, '0, 0);
    expect_rd("R1 fall", 2, '0, 0);
    expect_rd("R1 pend", 4, '0, 0);

    // R2 configuration readback
    wr(0, 23'h400007);
    wr(1, 23'h40000D);
    wr(2, 23'h000006);
    expect_rd("R2 ena", 0, 23'h400007, 0);
    expect_rd("R2 rise", 1, 23'h40000D, 0);
    expect_rd("R2 fall", 2, 23'h000006, 0);

    // R11 latency then R3 rising edge on line 0
    @(negedge clk);
    line_in[0] = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    expect_rd("R11 not yet", 4, 23'h0, 0);
    @(posedge clk);
    @(negedge clk);
    expect_rd("R3 R11 rise line0", 4, 23'h1, 1);

    // R4 falling-only line 1
    set_line(1, 1);
    expect_rd("R4 rise ignored", 4, 23'h1, 1);
    set_line(1, 0);
    expect_rd("R4 fall sets", 4, 23'h3, 1);

    // R6 masked line 3 with rise selected
    set_line(3, 1);
    expect_rd("R6 masked edge", 4, 23'h3, 1);
    set_line(3, 0);

    // R7 write-one-to-clear
    wr(4, 23'h1);
    expect_rd("R7 clear bit0", 4, 23'h2, 1);
    wr(4, 23'h2);
    expect_rd("R7 clear bit1", 4, 23'h0, 0);

    // R5 both edges on line 2
    set_line(2, 1);
    expect_rd("R5 rise", 4, 23'h4, 1);
    wr(4, 23'h4);
    expect_rd("R5 cleared", 4, 23'h0, 0);
    set_line(2, 0);
    expect_rd("R5 fall", 4, 23'h4, 1);

    // R8 clear coinciding with a new edge
    @(negedge clk);
    line_in[2] = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    reg_we = 1; reg_addr = 4; reg_wdata = 23'h4;
    @(posedge clk);
    @(negedge clk);
    reg_we = 0;
    expect_rd("R8 set wins", 4, 23'h4, 1);
    wr(4, 23'h4);
    expect_rd("R8 plain clear", 4, 23'h0, 0);

    // R12 top line
    set_line(22, 1);
    expect_rd("R12 line22", 4, 23'h400000, 1);
    wr(4, 23'h400000);
    expect_rd("R12 cleared", 4, 23'h0, 0);

    // R9 software set on disabled line, R10 request follows enable
    wr(3, 23'h8);
    expect_rd("R9 sw set", 4, 23'h8, 0);
    expect_rd("R9 sw reads 0", 3, 23'h0, 0);
    wr(0, 23'h40000F);
    expect_rd("R10 enable raises req", 4, 23'h8, 1);
    wr(4, 23'h8);
    expect_rd("R10 req drops", 4, 23'h0, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule